// File: doc/BRIEF.md
# 32-Pin I/O Bank with Dual Interrupt Lines

This block is a bank of 32 general-purpose pins behind a flat 32-bit register bus. Software configures each pin as a driven output or as an input. Each output latch bit can be written directly, or set and cleared through mask registers without a read-modify-write. Each input is passed through a two-flop synchroniser, and the synchronised level is readable. Each pin can also be watched for a low level, a high level, a rising edge or a falling edge. Any combination of these four conditions may be armed on a pin at the same time.

A detected event latches into a status register. There is one status register for each of the two interrupt lines, and each is set whatever the enables hold. Each line has its own enable mask, written through separate write-1-to-set and write-1-to-clear addresses. Each line also has its own write-1-to-clear status.

An interrupt output is high whenever any pin has both its status bit and that line's enable bit set. This lets two consumers, such as two processors, take interrupts from the same bank independently.

Top module: `gpio_bank32`

## Requirements
- R1: After reset:
  - every pin is an input (`pad_dir` all ones, offset 0x134 reads 0xFFFFFFFF);
  - the output latch is 0;
  - the detect, enable and status registers read 0;
  - both interrupt outputs are low.
- R2: A read of offset 0x000 returns 0x50600801, and a write to it has no effect. A read of an unmapped offset (for example 0x1F0) returns 0. A write to a raw status offset (0x024, 0x028) changes nothing.
- R3: Offset 0x134 holds the direction mask (1 = input, 0 = output) and drives `pad_dir`. Offset 0x13C holds the output latch, is readable, and drives `pad_out`.
- R4: Writing a mask to 0x194 sets the latch bits that are 1 in the mask. Writing a mask to 0x190 clears them. Bits that are 0 in the mask keep their value.
- R5: Offset 0x138 returns the pin levels through a two-flop synchroniser. A change on `pin_in` made between two rising edges is visible after the second of those edges that follow it.
- R6: Offsets 0x140 and 0x144 arm the low-level and high-level conditions. While an armed level is present, the status bit is set. A write-1-to-clear issued while the level persists leaves the bit set.
- R7: Offsets 0x148 and 0x14C arm the rising-edge and falling-edge conditions. One edge sets the status bit once. After it is cleared, the bit stays clear while the pin holds its new level.
- R8: Two detect types armed on the same pin both take effect. With rising and falling both armed, each transition sets the status bit.
- R9: Events set the status of both lines whatever the enables hold. The raw status is read at 0x024 (line 0) and 0x028 (line 1). The status masked by that line's enable is read at 0x02C and 0x030.
- R10: Writing 1s to 0x034 or 0x038 sets enable bits of line 0 or line 1. Writing 1s to 0x03C or 0x040 clears them. Both addresses of a line read back its enable mask.
- R11: Interrupt output k is high exactly when some pin has status and enable both set on line k. Writing 1s to 0x02C or 0x030 clears only that line's status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| pad_out | output | 32 | Output latch value driven to the pads |
| pad_dir | output | 32 | Direction mask, 1 = input, 0 = driven output |
| irq | output | 2 | Interrupt lines 1 and 0 |

## Verification
The hardest state to reach from the ports is a status bit that is re-set in the same cycle as its clear. This happens when a level condition is still true as the write-1-to-clear lands. The bench holds the pin at the armed level, issues the clear, and reads back immediately.

Equally awkward is a pin with two trigger types armed at once, as during a trigger switch. The stimulus arms falling detection while rising detection is still armed, then toggles the pin both ways. Each transition must set the status.

Line independence is reached by the following steps:
- letting one event set both lines;
- clearing or disabling only one of them;
- observing the other line's raw status and interrupt output.

// File: rtl/gpio_bank32.sv
module gpio_bank32 #(
  parameter int          NPINS  = 32,
  parameter int          AW     = 12,
  parameter logic [31:0] REV_ID = 32'h5060_0801
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_dir,
  output logic [1:0]       irq
);
  localparam logic [AW-1:0] A_REV  = AW'(12'h000);
  localparam logic [AW-1:0] A_RAW0 = AW'(12'h024);
  localparam logic [AW-1:0] A_RAW1 = AW'(12'h028);
  localparam logic [AW-1:0] A_ST0  = AW'(12'h02C);
  localparam logic [AW-1:0] A_ST1  = AW'(12'h030);
  localparam logic [AW-1:0] A_ES0  = AW'(12'h034);
  localparam logic [AW-1:0] A_ES1  = AW'(12'h038);
  localparam logic [AW-1:0] A_EC0  = AW'(12'h03C);
  localparam logic [AW-1:0] A_EC1  = AW'(12'h040);
  localparam logic [AW-1:0] A_DIR  = AW'(12'h134);
  localparam logic [AW-1:0] A_DIN  = AW'(12'h138);
  localparam logic [AW-1:0] A_DOUT = AW'(12'h13C);
  localparam logic [AW-1:0] A_LO   = AW'(12'h140);
  localparam logic [AW-1:0] A_HI   = AW'(12'h144);
  localparam logic [AW-1:0] A_RISE = AW'(12'h148);
  localparam logic [AW-1:0] A_FALL = AW'(12'h14C);
  localparam logic [AW-1:0] A_CLR  = AW'(12'h190);
  localparam logic [AW-1:0] A_SET  = AW'(12'h194);
  localparam logic [NPINS-1:0] ZERO = '0;

  logic [NPINS-1:0] dir_q, dout_q, sy1_q, sy2_q, prv_q;
  logic [NPINS-1:0] lo_q, hi_q, rise_q, fall_q, evt;
  logic [1:0][NPINS-1:0] st_q, en_q;
  logic [1:0] st_clr, en_set, en_clr;

  assign evt = (lo_q & ~sy2_q) | (hi_q & sy2_q)
             | (rise_q & sy2_q & ~prv_q) | (fall_q & ~sy2_q & prv_q);

  assign st_clr = {bus_we && bus_addr == A_ST1, bus_we && bus_addr == A_ST0};
  assign en_set = {bus_we && bus_addr == A_ES1, bus_we && bus_addr == A_ES0};
  assign en_clr = {bus_we && bus_addr == A_EC1, bus_we && bus_addr == A_EC0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q <= '0;
      sy2_q <= '0;
      prv_q <= '0;
    end else begin
      sy1_q <= pin_in;
      sy2_q <= sy1_q;
      prv_q <= sy2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      dout_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_DIR:   dir_q  <= bus_wdata;
        A_DOUT:  dout_q <= bus_wdata;
        A_SET:   dout_q <= dout_q | bus_wdata;
        A_CLR:   dout_q <= dout_q & ~bus_wdata;
        A_LO:    lo_q   <= bus_wdata;
        A_HI:    hi_q   <= bus_wdata;
        A_RISE:  rise_q <= bus_wdata;
        A_FALL:  fall_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[k] <= '0;
        en_q[k] <= '0;
      end else begin
        st_q[k] <= (st_q[k] & ~(st_clr[k] ? bus_wdata : ZERO)) | evt;
        en_q[k] <= (en_q[k] | (en_set[k] ? bus_wdata : ZERO))
                 & ~(en_clr[k] ? bus_wdata : ZERO);
      end
    end
    assign irq[k] = |(st_q[k] & en_q[k]);
  end

  always_comb begin
    case (bus_addr)
      A_REV:         bus_rdata = REV_ID[NPINS-1:0];
      A_RAW0:        bus_rdata = st_q[0];
      A_RAW1:        bus_rdata = st_q[1];
      A_ST0:         bus_rdata = st_q[0] & en_q[0];
      A_ST1:         bus_rdata = st_q[1] & en_q[1];
      A_ES0, A_EC0:  bus_rdata = en_q[0];
      A_ES1, A_EC1:  bus_rdata = en_q[1];
      A_DIR:         bus_rdata = dir_q;
      A_DIN:         bus_rdata = sy2_q;
      A_DOUT:        bus_rdata = dout_q;
      A_LO:          bus_rdata = lo_q;
      A_HI:          bus_rdata = hi_q;
      A_RISE:        bus_rdata = rise_q;
      A_FALL:        bus_rdata = fall_q;
      default:       bus_rdata = '0;
    endcase
  end

  assign pad_out = dout_q;
  assign pad_dir = dir_q;
endmodule

// File: rtl/gpio_bank32_chk.sv
module gpio_bank32_chk #(
  parameter int          NPINS  = 32,
  parameter int          AW     = 12,
  parameter logic [31:0] REV_ID = 32'h5060_0801
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_we,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] bus_rdata,
  input logic [NPINS-1:0] pin_in,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_dir,
  input logic [1:0]       irq
);
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd0) |-> (pad_dir == '1 && pad_out == '0 && irq == 2'b00));

  // R2
  rev_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && bus_addr == AW'(12'h000)) |-> bus_rdata == REV_ID[NPINS-1:0]);

  // R4
  set_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(12'h194)) |=> pad_out == ($past(pad_out) | $past(bus_wdata)));

  // R4
  clr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(12'h190)) |=> pad_out == ($past(pad_out) & ~$past(bus_wdata)));

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (bus_addr == AW'(12'h13C) || bus_addr == AW'(12'h190) ||
                 bus_addr == AW'(12'h194))) |=> $stable(pad_out));

  // R5
  datain_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && !bus_we && bus_addr == AW'(12'h138)) |-> bus_rdata == $past(pin_in, 2));

  // R10
  irq0_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(12'h03C) && &bus_wdata) |=> !irq[0]);

  // R11
  irq1_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(12'h040) && &bus_wdata) |=> !irq[1]);
endmodule

bind gpio_bank32 gpio_bank32_chk #(.NPINS(NPINS), .AW(AW), .REV_ID(REV_ID)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
  .pad_out(pad_out), .pad_dir(pad_dir), .irq(irq)
);

// File: tb/gpio_bank32_tb_top.sv
module gpio_bank32_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pins = '0;
  logic [31:0] pad_out, pad_dir;
  logic [1:0]  irq;
  int nvec = 0;
  int nbad = 0;

  always #10 clk = ~clk;

  gpio_bank32 dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .pin_in(pins), .pad_out(pad_out), .pad_dir(pad_dir), .irq(irq)
  );

  typedef struct packed {
    logic        w;
    logic [11:0] a;
    logic [31:0] d;
  } vec_t;

  // R2 R3 R4 R10 register vectors; for reads d is the expected value
  localparam int NV = 22;
  localparam vec_t VT [NV] = '{
    '{1'b0, 12'h000, 32'h5060_0801},
    '{1'b0, 12'h1F0, 32'h0000_0000},
    '{1'b1, 12'h134, 32'h0000_FFFF},
    '{1'b0, 12'h134, 32'h0000_FFFF},
    '{1'b1, 12'h13C, 32'hA5A5_A5A5},
    '{1'b0, 12'h13C, 32'hA5A5_A5A5},
    '{1'b1, 12'h194, 32'h0F00_0000},
    '{1'b0, 12'h13C, 32'hAFA5_A5A5},
    '{1'b1, 12'h190, 32'h0000_0005},
    '{1'b0, 12'h13C, 32'hAFA5_A5A0},
    '{1'b1, 12'h034, 32'h0000_000F},
    '{1'b0, 12'h034, 32'h0000_000F},
    '{1'b0, 12'h03C, 32'h0000_000F},
    '{1'b1, 12'h03C, 32'h0000_0003},
    '{1'b0, 12'h034, 32'h0000_000C},
    '{1'b1, 12'h038, 32'hF000_0000},
    '{1'b0, 12'h040, 32'hF000_0000},
    '{1'b1, 12'h000, 32'h1234_5678},
    '{1'b0, 12'h000, 32'h5060_0801},
    '{1'b1, 12'h024, 32'hFFFF_FFFF},
    '{1'b0, 12'h024, 32'h0000_0000},
    '{1'b0, 12'h028, 32'h0000_0000}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    addr = a; we = 1'b0;
    #1;
    check(rdata, e, tag);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    check(pad_dir, 32'hFFFF_FFFF, "R1 pad_dir");
    check(pad_out, 32'h0, "R1 pad_out");
    check({30'h0, irq}, 32'h0, "R1 irq");
    rd(12'h134, 32'hFFFF_FFFF, "R1 dir reg");
    rd(12'h13C, 32'h0, "R1 latch");
    rd(12'h140, 32'h0, "R1 detect");
    rd(12'h034, 32'h0, "R1 enable");
    rd(12'h024, 32'h0, "R1 status");

    for (int i = 0; i < NV; i++) begin
      if (VT[i].w) wr(VT[i].a, VT[i].d);
      else rd(VT[i].a, VT[i].d, $sformatf("vector %0d (R2/R3/R4/R10)", i));
    end
    check(pad_out, 32'hAFA5_A5A0, "R4 pad_out after set/clear");
    check(pad_dir, 32'h0000_FFFF, "R3 pad_dir");

    // R5 two-flop synchroniser latency
    cyc(1);
    pins = 32'h1234_5678;
    cyc(1);
    rd(12'h138, 32'h0, "R5 after one edge");
    cyc(1);
    rd(12'h138, 32'h1234_5678, "R5 after two edges");
    pins = '0;
    cyc(4);

    // R6 low level on pin 3 (line0 enable = 0xC, line1 = 0xF0000000)
    wr(12'h140, 32'h8);
    cyc(2);
    rd(12'h024, 32'h8, "R6 low level raw0");
    rd(12'h028, 32'h8, "R9 raw1 set without enable");
    rd(12'h02C, 32'h8, "R9 masked0");
    rd(12'h030, 32'h0, "R9 masked1");
    check({30'h0, irq}, 32'h1, "R11 irq0 only");
    wr(12'h02C, 32'h8);
    rd(12'h024, 32'h8, "R6 clear while level persists");
    pins[3] = 1'b1;
    cyc(4);
    wr(12'h02C, 32'h8);
    rd(12'h024, 32'h0, "R6 cleared after level gone");
    rd(12'h028, 32'h8, "R11 line1 kept");
    check({30'h0, irq}, 32'h0, "R11 irq low");
    wr(12'h140, 32'h0);

    // R6 high level on pin 4, not enabled on either line
    pins[4] = 1'b1;
    cyc(3);
    wr(12'h144, 32'h10);
    cyc(2);
    rd(12'h024, 32'h10, "R6 high level raw0");
    rd(12'h02C, 32'h0, "R9 masked0 without enable");
    check({30'h0, irq}, 32'h0, "R9 irq stays low");
    wr(12'h144, 32'h0);
    wr(12'h02C, 32'h10);
    wr(12'h030, 32'h18);
    rd(12'h028, 32'h0, "R11 line1 cleared");

    // R7 rising edge on pin 31
    wr(12'h148, 32'h8000_0000);
    pins[31] = 1'b1;
    cyc(4);
    rd(12'h028, 32'h8000_0000, "R7 rising raw1");
    check({30'h0, irq}, 32'h2, "R11 irq1 only");
    wr(12'h040, 32'h8000_0000);
    check({30'h0, irq}, 32'h0, "R10 enable clear drops irq1");
    rd(12'h030, 32'h0, "R10 masked1 disabled");
    rd(12'h028, 32'h8000_0000, "R9 raw1 kept while disabled");
    wr(12'h038, 32'h8000_0000);
    check({30'h0, irq}, 32'h2, "R10 enable set restores irq1");
    wr(12'h030, 32'h8000_0000);
    rd(12'h028, 32'h0, "R7 rising cleared");
    cyc(3);
    rd(12'h028, 32'h0, "R7 no re-set while high");
    rd(12'h024, 32'h8000_0000, "R11 line0 raw kept");
    wr(12'h02C, 32'h8000_0000);
    rd(12'h024, 32'h0, "R11 line0 cleared");

    // R8 rising and falling armed together
    wr(12'h14C, 32'h8000_0000);
    pins[31] = 1'b0;
    cyc(4);
    rd(12'h028, 32'h8000_0000, "R8 falling with rising armed");
    wr(12'h030, 32'h8000_0000);
    rd(12'h028, 32'h0, "R8 cleared");
    pins[31] = 1'b1;
    cyc(4);
    rd(12'h030, 32'h8000_0000, "R8 rising with falling armed");
    wr(12'h030, 32'h8000_0000);
    wr(12'h02C, 32'hFFFF_FFFF);
    rd(12'h028, 32'h0, "R8 final clear");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule